// File: doc/BRIEF.md
# First-Order Sigma-Delta Loop with Decimating Filter

This block is a digital model of a single-bit, first-order sigma-delta converter loop and the decimating filter behind it. A signed sample arrives on every clock, which is the oversampled rate. An accumulator integrates the difference between that sample and a feedback value of plus or minus full scale. The sign of the accumulator is the one-bit quantizer decision. The resulting bitstream has a density of ones that follows the input level.

A decimating filter turns the bitstream into one word every K clocks. It is either a plain ones counter (order 1) or a pair of cascaded integrate-and-comb stages (order 2, a triangular window). The word appears together with a single-cycle valid flag. When the host switches the analog multiplexer in front of the converter, it pulses the resync input. The filter then restarts from empty, and the first words after the restart are withheld, because their windows still contain old or missing bits.

Top module: `sdm_adc_top`

## Requirements
- R1: Full scale is FS = 2^(IN_W-1). The accumulator resets to 0. On each clock the bitstream bit is 1 when the accumulator is at or above zero and 0 otherwise. The accumulator then takes the value accumulator + sample − FS when the bit is 1, and accumulator + sample + FS when the bit is 0. The bit shown in a cycle therefore depends only on samples from earlier cycles.
- R2: For any input in [−FS, FS−1] the accumulator stays within [−2·FS, 2·FS−2] and never wraps. A constant input of −FS therefore gives a bitstream that becomes all zeros and stays all zeros.
- R3: After reset with a zero input, the bitstream alternates 1,0,1,0. Any window of 32 bits holds exactly 16 ones, and the settled output word is K^ORDER/2.
- R4: A constant input x gives a settled word within 2·K^(ORDER−1) of K^ORDER·(x+FS)/(2·FS). A more positive input therefore yields more ones and a larger word, and a more negative input yields fewer ones and a smaller word.
- R5: Once settled, word_valid_o is high for exactly one cycle in every K cycles.
- R6: A frame is K consecutive bits. For order 2, the word issued at the end of a frame is the sum of the most recent 2K−1 bits, weighted with bit i back (i = 0 for the newest bit) by min(i+1, 2K−1−i). For order 1 it is the count of ones in the frame. Bits from before the last clear count as zero. The word and the valid flag appear in the cycle after the last bit of the frame.
- R7: A resync pulse clears the filter and the frame position, and the bit of that cycle is dropped. The next cycle starts a new frame. The first ORDER frame ends after the pulse raise no valid, so the first valid comes (ORDER+1)·K+1 cycles after the resync cycle. Reset behaves in the same way. The modulator accumulator is not affected by resync.
- R8: Reset gives word_o = 0 and word_valid_o = 0. word_o changes only in a cycle where word_valid_o is high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, one input sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | IN_W | Signed two's-complement input sample |
| resync_i | input | 1 | Restart filter settling after an input channel change |
| bit_o | output | 1 | One-bit quantizer output stream |
| word_o | output | $clog2(K^ORDER+1) | Decimated output word, unsigned |
| word_valid_o | output | 1 | Single-cycle strobe marking a new settled word |

## Verification
The following are checked on every cycle:
- the accumulator range;
- the accumulator update from the previous sample and bit;
- the minimum spacing of K cycles between valid pulses;
- the silence of valid after a resync or reset for the full settling window;
- the word holding still whenever valid is low.

The following only the bench scenarios can show:
- the exact word values and the triangular weighting across frame boundaries;
- the equal split of ones and zeros at midscale;
- the monotonic relation between a DC input and the word;
- the all-zero bitstream at negative full scale;
- the exact cycle of the first valid after a mid-frame resync.

// File: rtl/sdm_pkg.sv
// Package: shared sizing helpers for the sigma-delta loop and its decimator.
// Assumes the filter order is 1 or 2 and the oversampling ratio is at least 2.
package sdm_pkg;

    // Width of the unsigned decimated word: it must hold K^order exactly.
    function automatic int word_width(input int k, input int order);
        int p;
        p = 1;
        for (int i = 0; i < order; i++) begin
            p = p * k;
        end
        return $clog2(p + 1);
    endfunction

    // Width of the loop accumulator: two guard bits over the sample width.
    function automatic int acc_width(input int in_w);
        return in_w + 2;
    endfunction

endpackage

// File: rtl/sdm_modulator.sv
// Module: first-order single-bit sigma-delta loop.
// One integrator accumulates sample minus a +/-FS feedback value, with
// FS = 2^(IN_W-1). The quantizer bit is the accumulator sign (1 when >= 0).
// The bit comes straight from the registered accumulator, so it has no
// combinational path from the input. Assumes the input lies in [-FS, FS-1];
// with two guard bits the accumulator stays in [-2FS, 2FS-2].
module sdm_modulator
    import sdm_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic signed [IN_W-1:0]          sample_i,
    output logic                            bit_o,
    output logic signed [acc_width(IN_W)-1:0] acc_o
);
    localparam int ACC_W = acc_width(IN_W);
    localparam logic signed [ACC_W-1:0] FB_POS = ACC_W'(2 ** (IN_W - 1));
    localparam logic signed [ACC_W-1:0] FB_NEG = -FB_POS;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W-1:0] sample_ext;
    logic                    decision;

    // Quantizer: sign of the integrator state.
    assign decision = ~acc_q[ACC_W-1];

    // Sign-extend the sample to accumulator width.
    assign sample_ext = {{(ACC_W - IN_W){sample_i[IN_W-1]}}, sample_i};

    // Next integrator value: add the sample, subtract the 1-bit DAC level.
    always_comb begin
        acc_d = acc_q + sample_ext - (decision ? FB_POS : FB_NEG);
    end

    // Integrator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign bit_o = decision;
    assign acc_o = acc_q;

endmodule

// File: rtl/sdm_decimator.sv
// Module: decimating filter for the bitstream.
// Keeps a frame position of K bits. In the last cycle of a frame it raises
// frame_end_o and presents word_o, which includes that cycle's bit.
// ORDER 1 counts the ones in the frame. ORDER 2 runs two integrators at the
// input rate and two combs at frame rate, which gives a triangular window of
// 2K-1 bits. The arithmetic is modular at OUT_W bits; this is exact because
// the true result never exceeds K^ORDER. A clear zeroes all state and
// restarts the frame, and the bit of the clear cycle is dropped.
module sdm_decimator
    import sdm_pkg::*;
#(
    parameter int K     = 16,
    parameter int ORDER = 2,
    parameter int OUT_W = word_width(16, 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             bit_i,
    output logic             frame_end_o,
    output logic [OUT_W-1:0] word_o
);
    localparam int PH_W = (K > 1) ? $clog2(K) : 1;

    logic [PH_W-1:0]  phase_q;
    logic             last_bit;
    logic [OUT_W-1:0] bit_ext;
    logic [OUT_W-1:0] word_c;

    assign last_bit    = (phase_q == PH_W'(K - 1));
    assign frame_end_o = last_bit && !clr_i;
    assign bit_ext     = {{(OUT_W - 1){1'b0}}, bit_i};

    // Frame position counter, restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            phase_q <= '0;
        end else if (last_bit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    generate
        if (ORDER == 1) begin : g_box
            logic [OUT_W-1:0] cnt_q;

            assign word_c = cnt_q + bit_ext;

            // Ones counter, emptied at each frame end.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    cnt_q <= '0;
                end else if (frame_end_o) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= word_c;
                end
            end
        end else begin : g_sinc2
            logic [OUT_W-1:0] int1_q;
            logic [OUT_W-1:0] int2_q;
            logic [OUT_W-1:0] int1_n;
            logic [OUT_W-1:0] int2_n;
            logic [OUT_W-1:0] mark2_q;
            logic [OUT_W-1:0] mark1_q;
            logic [OUT_W-1:0] comb1;

            assign int1_n = int1_q + bit_ext;
            assign int2_n = int2_q + int1_n;
            assign comb1  = int2_n - mark2_q;
            assign word_c = comb1 - mark1_q;

            // Integrator cascade at the oversampled rate.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    int1_q <= '0;
                    int2_q <= '0;
                end else begin
                    int1_q <= int1_n;
                    int2_q <= int2_n;
                end
            end

            // Comb delay registers, loaded once per frame.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    mark2_q <= '0;
                    mark1_q <= '0;
                end else if (frame_end_o) begin
                    mark2_q <= int2_n;
                    mark1_q <= comb1;
                end
            end
        end
    endgenerate

    assign word_o = word_c;

endmodule

// File: rtl/sdm_settle.sv
// Module: output register and settling gate.
// It registers the filter word at each frame end and raises a one-cycle
// valid. After a reset or a clear, it withholds the first ORDER frame ends,
// because their windows still hold bits from before the clear. The word
// register holds its value whenever no valid is issued.
module sdm_settle #(
    parameter int ORDER = 2,
    parameter int OUT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             frame_end_i,
    input  logic [OUT_W-1:0] word_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] word_o
);
    localparam int SK_W = $clog2(ORDER + 1);

    logic [SK_W-1:0]  skip_q;
    logic             valid_q;
    logic [OUT_W-1:0] word_q;

    // Settling counter and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            skip_q  <= SK_W'(ORDER);
            valid_q <= 1'b0;
        end else if (frame_end_i) begin
            if (skip_q != '0) begin
                skip_q  <= skip_q - SK_W'(1);
                valid_q <= 1'b0;
            end else begin
                valid_q <= 1'b1;
            end
        end else begin
            valid_q <= 1'b0;
        end
    end

    // Output word register, loaded only with a settled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (frame_end_i && !clr_i && (skip_q == '0)) begin
            word_q <= word_i;
        end
    end

    assign valid_o = valid_q;
    assign word_o  = word_q;

endmodule

// File: rtl/sdm_adc_top.sv
// Module: top of the sigma-delta loop with its decimating filter.
// Chain: modulator -> decimator -> settling gate. resync_i clears the filter
// and the settling gate only; the loop integrator keeps running across a
// channel change. Assumes the samples stay within [-2^(IN_W-1), 2^(IN_W-1)-1],
// K >= 2 and ORDER is 1 or 2.
module sdm_adc_top
    import sdm_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int K     = 16,
    parameter int ORDER = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic signed [IN_W-1:0]              sample_i,
    input  logic                                resync_i,
    output logic                                bit_o,
    output logic [word_width(K, ORDER)-1:0]     word_o,
    output logic                                word_valid_o
);
    localparam int OUT_W = word_width(K, ORDER);
    localparam int ACC_W = acc_width(IN_W);

    logic                    bit_w;
    logic signed [ACC_W-1:0] acc_w;
    logic                    frame_end_w;
    logic [OUT_W-1:0]        filt_word_w;

    sdm_modulator #(
        .IN_W (IN_W)
    ) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .bit_o    (bit_w),
        .acc_o    (acc_w)
    );

    sdm_decimator #(
        .K     (K),
        .ORDER (ORDER),
        .OUT_W (OUT_W)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (resync_i),
        .bit_i       (bit_w),
        .frame_end_o (frame_end_w),
        .word_o      (filt_word_w)
    );

    sdm_settle #(
        .ORDER (ORDER),
        .OUT_W (OUT_W)
    ) u_set (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (resync_i),
        .frame_end_i (frame_end_w),
        .word_i      (filt_word_w),
        .valid_o     (word_valid_o),
        .word_o      (word_o)
    );

    assign bit_o = bit_w;

endmodule

// File: rtl/sdm_checker.sv
// Module: assertion checker for sdm_adc_top, attached by bind.
// It observes the ports and the loop accumulator. Counters inside the checker
// measure the valid spacing and the quiet time after a clear, so no delay
// depends on a parameter.
module sdm_checker #(
    parameter int IN_W  = 8,
    parameter int K     = 16,
    parameter int ORDER = 2,
    parameter int OUT_W = 9,
    parameter int ACC_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [IN_W-1:0]  sample_i,
    input logic                    resync_i,
    input logic                    bit_o,
    input logic [OUT_W-1:0]        word_o,
    input logic                    word_valid_o,
    input logic signed [ACC_W-1:0] acc
);
    localparam int FS    = 2 ** (IN_W - 1);
    localparam int GAP_W = $clog2(K + 1);
    localparam int QT    = (ORDER + 1) * K;
    localparam int CLR_W = $clog2(QT + 1);
    localparam logic signed [ACC_W-1:0] LO_LIM = ACC_W'(-2 * FS);
    localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'(2 * FS - 2);
    localparam logic signed [ACC_W-1:0] FS_V   = ACC_W'(FS);

    logic [GAP_W-1:0]        gap_q;
    logic                    seen_q;
    logic [CLR_W-1:0]        quiet_q;
    logic signed [ACC_W-1:0] step_exp;

    // Expected accumulator after this cycle, from the ports and the bit.
    assign step_exp = acc + {{(ACC_W - IN_W){sample_i[IN_W-1]}}, sample_i}
                      + (bit_o ? -FS_V : FS_V);

    // Cycles since the last valid, saturating at K.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (word_valid_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q < GAP_W'(K)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // Cycles since the last reset or resync, saturating at the quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n || resync_i) begin
            quiet_q <= '0;
        end else if (quiet_q < CLR_W'(QT)) begin
            quiet_q <= quiet_q + CLR_W'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc >= LO_LIM) && (acc <= HI_LIM)); // R2

    AST_LOOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acc == $past(step_exp))); // R1

    AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && seen_q) |-> (gap_q >= GAP_W'(K - 1))); // R5

    AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (quiet_q >= CLR_W'(QT))); // R7

    AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> !word_valid_o); // R7

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid_o |-> $stable(word_o)); // R8

endmodule

bind sdm_adc_top sdm_checker #(
    .IN_W  (IN_W),
    .K     (K),
    .ORDER (ORDER),
    .OUT_W (OUT_W),
    .ACC_W (ACC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .resync_i     (resync_i),
    .bit_o        (bit_o),
    .word_o       (word_o),
    .word_valid_o (word_valid_o),
    .acc          (acc_w)
);

// File: tb/tb_sdm_adc_top.sv
// Bench: a behavioural reference model of the loop and filter, compared with
// the outputs on every clock, plus scenario checks of the density, the
// settling and the valid spacing.
module tb_sdm_adc_top;
    localparam int IN_W  = 8;
    localparam int K     = 16;
    localparam int ORDER = 2;
    localparam int FS    = 2 ** (IN_W - 1);
    localparam int OUT_W = sdm_pkg::word_width(K, ORDER);
    localparam int FULL  = K ** ORDER;
    localparam int TAPS  = (ORDER == 1) ? K : 2 * K - 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic signed [IN_W-1:0] sample = '0;
    logic                   resync = 1'b0;
    logic                   bit_o;
    logic [OUT_W-1:0]       word_o;
    logic                   word_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit track  = 1'b0;

    // Reference model state.
    int m_acc   = 0;
    int m_bits[$];
    int m_phase = 0;
    int m_skip  = ORDER;
    int m_valid = 0;
    int m_word  = 0;

    sdm_adc_top #(.IN_W(IN_W), .K(K), .ORDER(ORDER)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample),
        .resync_i     (resync),
        .bit_o        (bit_o),
        .word_o       (word_o),
        .word_valid_o (word_valid_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int weight(input int i);
        if (ORDER == 1) return 1;
        return (i + 1 < TAPS - i) ? i + 1 : TAPS - i;
    endfunction

    // Reference model: advance one oversampled clock.
    always @(posedge clk) begin
        int b;
        int y;
        if (!rst_n) begin
            m_acc = 0; m_bits.delete(); m_phase = 0;
            m_skip = ORDER; m_valid = 0; m_word = 0;
        end else begin
            b = (m_acc >= 0) ? 1 : 0;
            if (resync) begin
                m_bits.delete(); m_phase = 0; m_skip = ORDER; m_valid = 0;
            end else begin
                m_bits.push_front(b);
                if (m_bits.size() > TAPS) void'(m_bits.pop_back());
                if (m_phase == K - 1) begin
                    m_phase = 0;
                    y = 0;
                    for (int i = 0; i < m_bits.size(); i++) y += weight(i) * m_bits[i];
                    if (m_skip > 0) begin
                        m_skip--; m_valid = 0;
                    end else begin
                        m_valid = 1; m_word = y;
                    end
                end else begin
                    m_phase++; m_valid = 0;
                end
            end
            m_acc = m_acc + int'(sample) - (b ? FS : -FS);
        end
    end

    // Cycle-by-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && track) begin
            check(bit_o === ((m_acc >= 0) ? 1'b1 : 1'b0), "R1 R2 bitstream",
                  int'(bit_o), (m_acc >= 0) ? 1 : 0);
            check(word_valid_o === m_valid[0], "R5 R7 valid", int'(word_valid_o), m_valid);
            check(int'(word_o) == m_word, "R6 R8 word", int'(word_o), m_word);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ones(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(bit_o);
        end
    endtask

    task automatic near(input string tag, input int exp, input int tol);
        int d;
        d = int'(word_o) - exp;
        if (d < 0) d = -d;
        check(d <= tol, tag, int'(word_o), exp);
    endtask

    initial begin
        int c;
        int n;
        // Reset state, R8 and R1.
        cycles(3);
        check(word_valid_o === 1'b0, "R8 reset valid", int'(word_valid_o), 0);
        check(word_o === '0, "R8 reset word", int'(word_o), 0);
        check(bit_o === 1'b1, "R1 reset bit", int'(bit_o), 1);
        rst_n = 1'b1;
        track = 1'b1;

        // Midscale input, R3.
        ones(32, c);
        check(c == 16, "R3 ones in 32 bits", c, 16);
        cycles(5 * K);
        check(int'(word_o) == FULL / 2, "R3 settled word", int'(word_o), FULL / 2);

        // Positive input, R4.
        sample = 8'sd64;
        cycles(6 * K);
        near("R4 word for +64", FULL * (64 + FS) / (2 * FS), 2 * (FULL / K));
        ones(64, c);
        check(c >= 46 && c <= 50, "R4 ones for +64", c, 48);

        // Negative input, R4.
        sample = -8'sd64;
        cycles(6 * K);
        near("R4 word for -64", FULL * (FS - 64) / (2 * FS), 2 * (FULL / K));

        // Full-scale extremes, R2.
        sample = -8'sd128;
        cycles(8 * K);
        ones(64, c);
        check(c == 0, "R2 ones at -FS", c, 0);
        check(int'(word_o) == 0, "R2 word at -FS", int'(word_o), 0);
        sample = 8'sd127;
        cycles(8 * K);
        ones(64, c);
        check(c >= 63, "R2 ones at FS-1", c, 64);
        for (int i = 0; i < 300; i++) begin
            sample = (i % 2 == 0) ? 8'sd127 : -8'sd128;
            @(negedge clk);
        end

        // Valid spacing, R5.
        sample = 8'sd10;
        while (!word_valid_o) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!word_valid_o);
        check(n == K, "R5 valid spacing", n, K);

        // Mid-frame resync, R7.
        cycles(5);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        n = 1;
        while (!word_valid_o && n < 10 * K) begin
            @(negedge clk);
            n++;
        end
        check(n == (ORDER + 1) * K + 1, "R7 first valid after resync", n, (ORDER + 1) * K + 1);

        // Random samples with occasional resync, R6 via the model.
        for (int i = 0; i < 3000; i++) begin
            sample = IN_W'($urandom);
            resync = ($urandom_range(0, 199) == 0);
            @(negedge clk);
        end
        resync = 1'b0;
        sample = '0;
        cycles(4 * K);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule